// File: doc/BRIEF.md
# Bidirectional Cascadable Segment Shift Register

This block is the serial front end of a segment display driver. Segment data arrives one bit per clock and is held in a long shift register. By default the register is 280 bits long, arranged as 140 segment pairs. Its full contents are presented in parallel to a latch further down the chip, which is outside this block.

A static direction strap decides which side of the die is the input side. It selects which of two data pads and which of two clock pads are used, and which end of the register new data enters at. The active clock is passed straight through to the clock pad on the opposite side. The bit at the exit end is re-registered on the falling edge of the active clock and driven on both serial output pads. Chips can therefore be chained in either orientation, and the next chip samples stable data on its own rising edge.

Top module: `segShiftCascade`

## Requirements
- R1: With `dirSel` = 1 only `serInA` and `clkInA` affect the register. With `dirSel` = 0 only `serInB` and `clkInB` do. Activity on the other data and clock pads changes no output.
- R2: With `dirSel` = 1, each rising edge of the active clock loads the data bit into index 0 and moves every other bit up by one index. The first bit of a stream of `2*NUM_PAIRS` bits therefore ends at the highest index.
- R3: With `dirSel` = 0, each rising edge loads the data bit into the highest index and moves every other bit down by one index. The first bit of a full stream ends at index 0.
- R4: With `dirSel` = 1, `clkOutB` follows `clkInA` and `clkOutA` stays 0. With `dirSel` = 0, `clkOutA` follows `clkInB` and `clkOutB` stays 0.
- R5: The serial output takes the exit-end bit on the falling edge of the active clock. The exit end is the highest index when `dirSel` = 1 and index 0 when `dirSel` = 0. Between a rising edge and the following falling edge the serial output keeps its previous value.
- R6: `serOutA` and `serOutB` always carry the same value.
- R7: While `rstN` is low, the register and the serial output are cleared to 0 without waiting for a clock edge.
- R8: Pair p (1-based), bit b (1 or 2) appears on `parData` at index 2*(p-1)+(b-1).
- R9: Two instances with the same `dirSel` can be chained. The first instance's forwarded clock and serial output drive the second instance's active clock and data pads. The chain then behaves as one shift register of twice the length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rstN | input | 1 | Asynchronous active-low reset |
| dirSel | input | 1 | Static direction strap |
| serInA | input | 1 | Serial data pad, side A |
| serInB | input | 1 | Serial data pad, side B |
| clkInA | input | 1 | Shift clock pad, side A |
| clkInB | input | 1 | Shift clock pad, side B |
| serOutA | output | 1 | Retimed serial output, side A |
| serOutB | output | 1 | Retimed serial output, side B |
| clkOutA | output | 1 | Forwarded clock, side A |
| clkOutB | output | 1 | Forwarded clock, side B |
| parData | output | 2*NUM_PAIRS | Parallel register contents |

## Verification
The hardest case to reach is the half-period window. The first chip's serial output must stay stable through the rising edge at which the second chip samples it, and change only at the falling edge. The stimulus reaches it with two 4-pair instances chained in each strap setting. Every bit is driven with explicit rise and fall phases of the active pad clock. The serial output is sampled between the edges and again after the fall, and both parallel buses are compared against a 16-bit chain model.

// File: rtl/segShiftPkg.sv
package segShiftPkg;

  // Strobes from the pad-selection control into the datapath.
  typedef struct packed {
    logic shiftUp;  // 1: enter at index 0 and move up; 0: enter at top and move down
    logic dataIn;   // serial bit taken from the active data pad
  } shiftStrobeT;

endpackage

// File: rtl/segShiftCtrl.sv
module segShiftCtrl
  import segShiftPkg::*;
(
  input  logic        dirSel,
  input  logic        serInA,
  input  logic        serInB,
  input  logic        clkInA,
  input  logic        clkInB,
  output logic        activeClk,
  output logic        clkOutA,
  output logic        clkOutB,
  output shiftStrobeT strobe
);

  // The strap is static, so the clock multiplexer never switches during operation.
  always_comb begin
    activeClk      = dirSel ? clkInA : clkInB;
    strobe.shiftUp = dirSel;
    strobe.dataIn  = dirSel ? serInA : serInB;
    // The active clock is forwarded to the far side; the unused side is held low.
    clkOutB        = dirSel ? clkInA : 1'b0;
    clkOutA        = dirSel ? 1'b0   : clkInB;
  end

endmodule

// File: rtl/segShiftPath.sv
module segShiftPath
  import segShiftPkg::*;
#(
  parameter int NUM_BITS = 280
) (
  input  logic                clk,
  input  logic                rstN,
  input  shiftStrobeT         strobe,
  output logic [NUM_BITS-1:0] parData,
  output logic                serOut
);

  localparam int TOP = NUM_BITS - 1;

  logic [NUM_BITS-1:0] shReg;
  logic [NUM_BITS-1:0] nextReg;
  logic                exitBit;
  logic                posArmed;
  logic                negArmed;

  // Each bit takes its lower neighbour when shifting up and its upper neighbour when shifting down.
  for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
    logic upSrc;
    logic dnSrc;
    if (i == 0) begin : g_low
      assign upSrc = strobe.dataIn;
    end else begin : g_lowN
      assign upSrc = shReg[i-1];
    end
    if (i == TOP) begin : g_high
      assign dnSrc = strobe.dataIn;
    end else begin : g_highN
      assign dnSrc = shReg[i+1];
    end
    assign nextReg[i] = strobe.shiftUp ? upSrc : dnSrc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      posArmed <= 1'b0;
    end else begin
      shReg    <= nextReg;
      posArmed <= 1'b1;
    end
  end

  assign exitBit = strobe.shiftUp ? shReg[TOP] : shReg[0];

  // The falling-edge flop delays the exit bit by half a clock for the next chip in the chain.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      serOut   <= 1'b0;
      negArmed <= 1'b0;
    end else begin
      serOut   <= exitBit;
      negArmed <= 1'b1;
    end
  end

  assign parData = shReg;

  a_r2_entry_low: assert property (@(posedge clk) disable iff (!rstN)
    (posArmed && strobe.shiftUp) |-> shReg[0] == $past(strobe.dataIn));

  a_r2_move_up: assert property (@(posedge clk) disable iff (!rstN)
    (posArmed && strobe.shiftUp) |-> shReg[1] == $past(shReg[0]));

  a_r3_entry_high: assert property (@(posedge clk) disable iff (!rstN)
    (posArmed && !strobe.shiftUp) |-> shReg[TOP] == $past(strobe.dataIn));

  a_r3_move_down: assert property (@(posedge clk) disable iff (!rstN)
    (posArmed && !strobe.shiftUp) |-> shReg[TOP-1] == $past(shReg[TOP]));

  a_r5_half_retime: assert property (@(negedge clk) disable iff (!rstN)
    negArmed |-> serOut == $past(exitBit));

endmodule

// File: rtl/segShiftCascade.sv
module segShiftCascade
  import segShiftPkg::*;
#(
  parameter int NUM_PAIRS = 140
) (
  input  logic                   rstN,
  input  logic                   dirSel,
  input  logic                   serInA,
  input  logic                   serInB,
  input  logic                   clkInA,
  input  logic                   clkInB,
  output logic                   serOutA,
  output logic                   serOutB,
  output logic                   clkOutA,
  output logic                   clkOutB,
  output logic [2*NUM_PAIRS-1:0] parData
);

  localparam int NUM_BITS = 2 * NUM_PAIRS;

  logic        activeClk;
  logic        serOut;
  shiftStrobeT strobe;

  segShiftCtrl u_ctrl (
    .dirSel    (dirSel),
    .serInA    (serInA),
    .serInB    (serInB),
    .clkInA    (clkInA),
    .clkInB    (clkInB),
    .activeClk (activeClk),
    .clkOutA   (clkOutA),
    .clkOutB   (clkOutB),
    .strobe    (strobe)
  );

  segShiftPath #(.NUM_BITS(NUM_BITS)) u_path (
    .clk     (activeClk),
    .rstN    (rstN),
    .strobe  (strobe),
    .parData (parData),
    .serOut  (serOut)
  );

  // R6: one retimed bit drives both sides of the die.
  assign serOutA = serOut;
  assign serOutB = serOut;

endmodule

// File: tb/segShiftCascade_tb.sv
module segShiftCascade_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NB = 2 * NP;
  localparam int CB = 2 * NB;

  logic rstN, dirSel, dinA, dinB, clkA, clkB;
  logic firstSerA, firstSerB, firstClkA, firstClkB;
  logic nextSerA, nextSerB, nextClkA, nextClkB;
  logic [NB-1:0] firstPar, nextPar;
  logic [CB-1:0] model;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  segShiftCascade #(.NUM_PAIRS(NP)) u_dut (
    .rstN(rstN), .dirSel(dirSel), .serInA(dinA), .serInB(dinB),
    .clkInA(clkA), .clkInB(clkB), .serOutA(firstSerA), .serOutB(firstSerB),
    .clkOutA(firstClkA), .clkOutB(firstClkB), .parData(firstPar)
  );

  // Second chip: each of its pads takes the first chip's pad on the facing side.
  segShiftCascade #(.NUM_PAIRS(NP)) u_next (
    .rstN(rstN), .dirSel(dirSel), .serInA(firstSerB), .serInB(firstSerA),
    .clkInA(firstClkB), .clkInB(firstClkA), .serOutA(nextSerA), .serOutB(nextSerB),
    .clkOutA(nextClkA), .clkOutB(nextClkB), .parData(nextPar)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] expFirst();
    return dirSel ? model[NB-1:0] : model[CB-1:NB];
  endfunction

  function automatic logic [NB-1:0] expNext();
    return dirSel ? model[CB-1:NB] : model[NB-1:0];
  endfunction

  task automatic shiftOne(input logic b);
    logic prevSer;
    if (dirSel) begin dinA = b; dinB = ~b; end
    else begin dinB = b; dinA = ~b; end
    #(CLK_PERIOD/5);
    prevSer = nextSerA;
    if (dirSel) clkA = 1'b1; else clkB = 1'b1;
    if (dirSel) model = {model[CB-2:0], b};
    else model = {b, model[CB-1:1]};
    #(CLK_PERIOD/5);
    chk(firstPar == expFirst(), dirSel ? "R2 first chip" : "R3 first chip", 32'(firstPar), 32'(expFirst()));
    chk(nextPar == expNext(), "R9 second chip contents", 32'(nextPar), 32'(expNext()));
    chk(nextSerA == prevSer, "R5 holds until falling edge", 32'(nextSerA), 32'(prevSer));
    if (dirSel)
      chk(firstClkB == 1'b1 && firstClkA == 1'b0, "R4 forward to B", {30'd0, firstClkA, firstClkB}, 32'd1);
    else
      chk(firstClkA == 1'b1 && firstClkB == 1'b0, "R4 forward to A", {30'd0, firstClkA, firstClkB}, 32'd2);
    #(CLK_PERIOD/10);
    if (dirSel) clkA = 1'b0; else clkB = 1'b0;
    #(CLK_PERIOD/5);
    chk(nextSerA == (dirSel ? model[CB-1] : model[0]), "R5 chain exit bit",
        32'(nextSerA), 32'(dirSel ? model[CB-1] : model[0]));
    chk(nextSerA == nextSerB, "R6 both outputs agree", 32'(nextSerA), 32'(nextSerB));
    chk(firstSerB == (dirSel ? model[NB-1] : model[NB]), "R5 first chip exit bit",
        32'(firstSerB), 32'(dirSel ? model[NB-1] : model[NB]));
    #(CLK_PERIOD*3/10);
  endtask

  function automatic logic patBit(input int p, input int i);
    case (p)
      0: return 1'b1;
      1: return logic'(i % 2);
      2: return ((i * 5 + 1) % 7) < 3;
      default: return (i % 3) == 0;
    endcase
  endfunction

  // R1: pulses on the unused clock pad, with the unused data pad toggling, must change nothing.
  task automatic idlePadPulses();
    logic [NB-1:0] snapFirst, snapNext;
    logic snapSer;
    snapFirst = firstPar;
    snapNext = nextPar;
    snapSer = nextSerA;
    for (int k = 0; k < 3; k++) begin
      if (dirSel) begin dinB = logic'(k % 2); clkB = 1'b1; end
      else begin dinA = logic'(k % 2); clkA = 1'b1; end
      #(CLK_PERIOD/2);
      chk(dirSel ? firstClkA == 1'b0 : firstClkB == 1'b0, "R4 idle side low", 32'(dirSel ? firstClkA : firstClkB), 32'd0);
      if (dirSel) clkB = 1'b0; else clkA = 1'b0;
      #(CLK_PERIOD/2);
    end
    chk(firstPar == snapFirst, "R1 unused pads ignored (first)", 32'(firstPar), 32'(snapFirst));
    chk(nextPar == snapNext, "R1 unused pads ignored (second)", 32'(nextPar), 32'(snapNext));
    chk(nextSerA == snapSer, "R1 unused pads leave output", 32'(nextSerA), 32'(snapSer));
  endtask

  task automatic checkCleared(input string req);
    chk(firstPar == '0, req, 32'(firstPar), 32'd0);
    chk(nextPar == '0, req, 32'(nextPar), 32'd0);
    chk(firstSerA == 1'b0 && nextSerB == 1'b0, req, {30'd0, firstSerA, nextSerB}, 32'd0);
  endtask

  initial begin
    rstN = 1'b0; dirSel = 1'b1; dinA = 1'b0; dinB = 1'b0; clkA = 1'b0; clkB = 1'b0;
    model = '0;
    for (int d = 1; d >= 0; d--) begin
      rstN = 1'b0;
      dirSel = logic'(d);
      model = '0;
      #(CLK_PERIOD*7/10);
      checkCleared("R7 reset state");
      rstN = 1'b1;
      #(CLK_PERIOD*3/10);
      // R8: a single first bit lands on pair 1 bit 1 (index 0) or on the last pair's bit 2 (top index).
      shiftOne(1'b1);
      chk(firstPar == (d == 1 ? NB'(1) : NB'(1) << (NB - 1)), "R8 pair index mapping",
          32'(firstPar), 32'(d == 1 ? NB'(1) : NB'(1) << (NB - 1)));
      for (int p = 0; p < 4; p++) begin
        for (int i = 0; i < CB + 2; i++) shiftOne(patBit(p, i));
        idlePadPulses();
      end
      // R7: an asynchronous clear in the middle of a stream.
      rstN = 1'b0;
      #(CLK_PERIOD/5);
      checkCleared("R7 async clear mid-stream");
      model = '0;
      rstN = 1'b1;
      #(CLK_PERIOD/5);
      for (int i = 0; i < NB; i++) shiftOne(patBit(2, i + 3));
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule